// File: doc/BRIEF.md
# Refill-in-place single-slot queue

This block is a queue with exactly one storage slot. It holds one data word of a configurable width. It is meant to sit inside a recirculating datapath, where an item taken out of the slot is often replaced by another item in the same clock cycle. The slot therefore never loses a cycle to a drain followed by a fill.

There are four operations, each with its own handshake:
- **Push** is an enable and a data word, with a ready signal back to the sender.
- **Pop** is an enable, with a ready signal back.
- **Head read** is a valid flag and the stored word.
- **Flush** is synchronous.

A push is accepted while the slot is occupied, as long as a pop is asserted in that same cycle. The result is the same as if the pop were handled first and the push second. To make this possible, push-ready depends combinationally on the pop enable.

Any enable raised while its ready is low is ignored. Flush takes priority over every other operation in its cycle.

Top module: `refill_slot_queue`

## Requirements
- R1: After an active-low reset the slot is empty: head_valid is 0, pop_ready is 0 and push_ready is 1.
- R2: A push accepted into an empty slot (push_en with push_ready high, no flush) makes head_valid 1 after the next rising edge, and head_data then equals the pushed word.
- R3: pop_ready equals head_valid. A pop on an occupied slot with no push and no flush leaves the slot empty after the edge.
- R4: While the slot is occupied and pop_en is low, push_ready is 0. A push_en raised in that state is ignored: the slot stays occupied and head_data is unchanged.
- R5: While the slot is occupied and pop_en is high, push_ready is 1 in the same cycle. A push together with that pop leaves the slot occupied, with head_data equal to the new word.
- R6: A pop_en on an empty slot has no effect: the slot stays empty. If a push is made in that same cycle, the push still fills the slot normally.
- R7: Flush empties the slot at the next edge. It overrides any push and any pop raised in the same cycle, so the pushed word is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Synchronous clear of the slot, highest priority |
| push_en | input | 1 | Push request |
| push_data | input | DATA_W | Word to store on an accepted push |
| push_ready | output | 1 | Slot can take a push this cycle (empty, or pop_en high) |
| pop_en | input | 1 | Pop request |
| pop_ready | output | 1 | Slot holds a word that may be popped |
| head_valid | output | 1 | head_data is meaningful |
| head_data | output | DATA_W | Stored word |

## Verification
The hardest case to reach is the same-cycle swap. The slot must already be occupied, and in one cycle the pop enable must raise push-ready combinationally while a new word is offered. The result is only visible at the ports one edge later.

The stimulus first fills the slot. It then drives pop and push together on consecutive cycles with distinct words. Push-ready is sampled after the pop enable settles but before the edge. The head word is checked after the edge, so a design that drops the swap or keeps the old word is exposed.

Flush is also combined with a simultaneous push and pop. This shows that the override discards the offered word.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    // Registered control state of the slot.
    typedef struct packed {
        logic occupied;
    } slot_ctl_t;

    // Handshake results produced by the control logic for one cycle.
    typedef struct packed {
        logic push_ready;
        logic pop_ready;
        logic push_take;
        logic pop_take;
    } slot_hs_t;

    localparam slot_ctl_t SLOT_CTL_RESET = '{occupied: 1'b0};

endpackage

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
    import rsq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flush,
    input  logic     push_en,
    input  logic     pop_en,
    output slot_hs_t hs,
    output logic     occupied_q,
    output logic     write_en
);

    slot_ctl_t ctl_d;
    slot_ctl_t ctl_q;
    slot_hs_t  hs_c;

    always_comb begin
        ctl_d = ctl_q;

        // Pop only counts when something is held.
        hs_c.pop_ready  = ctl_q.occupied;
        hs_c.pop_take   = pop_en & ctl_q.occupied;

        // Drain happens logically before fill: a pop in this cycle frees the slot.
        hs_c.push_ready = ~ctl_q.occupied | pop_en;
        hs_c.push_take  = push_en & hs_c.push_ready;

        if (flush) begin
            ctl_d.occupied = 1'b0;
        end else if (hs_c.push_take) begin
            ctl_d.occupied = 1'b1;
        end else if (hs_c.pop_take) begin
            ctl_d.occupied = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= SLOT_CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign hs         = hs_c;
    assign occupied_q = ctl_q.occupied;
    assign write_en   = hs_c.push_take & ~flush;

    // Pop on an empty slot with no push leaves it empty.
    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.occupied && !push_en && !flush) |=> !ctl_q.occupied);

    // A pop with no push drains the slot.
    assert_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.occupied && pop_en && !push_en && !flush) |=> !ctl_q.occupied);

endmodule

// File: rtl/rsq_store.sv
module rsq_store #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              write_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] data_q
);

    logic [DATA_W-1:0] data_d;

    always_comb begin
        data_d = data_q;
        if (write_en) begin
            data_d = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

endmodule

// File: rtl/refill_slot_queue.sv
module refill_slot_queue
    import rsq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    input  logic              pop_en,
    output logic              pop_ready,
    output logic              head_valid,
    output logic [DATA_W-1:0] head_data
);

    slot_hs_t          hs;
    logic              occupied_q;
    logic              write_en;
    logic [DATA_W-1:0] data_q;

    rsq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push_en    (push_en),
        .pop_en     (pop_en),
        .hs         (hs),
        .occupied_q (occupied_q),
        .write_en   (write_en)
    );

    rsq_store #(.DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .write_en (write_en),
        .wr_data  (push_data),
        .data_q   (data_q)
    );

    assign push_ready = hs.push_ready;
    assign pop_ready  = hs.pop_ready;
    assign head_valid = occupied_q;
    assign head_data  = data_q;

    // Reset leaves the slot empty.
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> !head_valid);

    // Accepted push into an empty slot stores the word.
    assert_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!head_valid && push_en && !flush) |=> (head_valid && head_data == $past(push_data)));

    // Occupied slot without pop holds its word and refuses pushes.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !pop_en && !flush) |=> (head_valid && $stable(head_data)));

    // Same-cycle pop and push swaps in the new word.
    assert_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && pop_en && push_en && !flush) |=> (head_valid && head_data == $past(push_data)));

    // Flush wins over everything.
    assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !head_valid);

endmodule

// File: tb/refill_slot_queue_tb_top.sv
`timescale 1ns/1ps
module refill_slot_queue_tb_top;

    localparam int DW   = 16;
    localparam int VW   = 3 + DW + 2 + DW;
    localparam int NVEC = 12;

    // Fields: flush, push, pop, push word, exp push_ready, exp occupied after, exp word after
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 1'b0, 16'hA001, 1'b1, 1'b1, 16'hA001}, // R2 fill
        {1'b0, 1'b1, 1'b0, 16'hB002, 1'b0, 1'b1, 16'hA001}, // R4 refused push
        {1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'hA001}, // R4 idle hold
        {1'b0, 1'b1, 1'b1, 16'hC003, 1'b1, 1'b1, 16'hC003}, // R5 swap
        {1'b0, 1'b1, 1'b1, 16'hD004, 1'b1, 1'b1, 16'hD004}, // R5 swap again
        {1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 16'h0000}, // R3 drain
        {1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 16'h0000}, // R6 pop on empty
        {1'b0, 1'b1, 1'b1, 16'hE005, 1'b1, 1'b1, 16'hE005}, // R6 push+pop on empty
        {1'b1, 1'b1, 1'b0, 16'hF006, 1'b0, 1'b0, 16'h0000}, // R7 flush when full
        {1'b1, 1'b1, 1'b0, 16'h1007, 1'b1, 1'b0, 16'h0000}, // R7 flush beats push
        {1'b0, 1'b1, 1'b0, 16'h2008, 1'b1, 1'b1, 16'h2008}, // R2 refill
        {1'b1, 1'b1, 1'b1, 16'h3009, 1'b1, 1'b0, 16'h0000}  // R7 flush beats swap
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          flush;
    logic          push_en;
    logic [DW-1:0] push_data;
    logic          push_ready;
    logic          pop_en;
    logic          pop_ready;
    logic          head_valid;
    logic [DW-1:0] head_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    refill_slot_queue #(.DATA_W(DW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push_en    (push_en),
        .push_data  (push_data),
        .push_ready (push_ready),
        .pop_en     (pop_en),
        .pop_ready  (pop_ready),
        .head_valid (head_valid),
        .head_data  (head_data)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        flush     = 1'b0;
        push_en   = 1'b0;
        pop_en    = 1'b0;
        push_data = '0;
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic prev_occ;
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 head_valid", DW'(head_valid), DW'(1'b0));
        check("R1 pop_ready",  DW'(pop_ready),  DW'(1'b0));
        check("R1 push_ready", DW'(push_ready), DW'(1'b1));
        @(negedge clk);
        rst_n = 1'b1;

        prev_occ = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            @(negedge clk);
            flush     = v[VW-1];
            push_en   = v[VW-2];
            pop_en    = v[VW-3];
            push_data = v[VW-4 -: DW];
            #1;
            check($sformatf("R4/R5 push_ready vec%0d", i), DW'(push_ready), DW'(v[DW+1]));
            check($sformatf("R3 pop_ready vec%0d", i), DW'(pop_ready), DW'(prev_occ));
            @(posedge clk);
            #1;
            check($sformatf("R2-R7 occupied vec%0d", i), DW'(head_valid), DW'(v[DW]));
            if (v[DW]) begin
                check($sformatf("R2/R5 head word vec%0d", i), head_data, v[DW-1:0]);
            end
            prev_occ = v[DW];
            idle_inputs();
        end

        // R1: reset in the middle of operation empties an occupied slot.
        @(negedge clk);
        push_en   = 1'b1;
        push_data = 16'h5A5A;
        @(negedge clk);
        idle_inputs();
        check("R2 pre-reset fill", DW'(head_valid), DW'(1'b1));
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid-run reset head_valid", DW'(head_valid), DW'(1'b0));
        check("R1 mid-run reset push_ready", DW'(push_ready), DW'(1'b1));
        @(negedge clk);
        rst_n = 1'b1;

        // R4: a long run of refused pushes keeps the first word.
        @(negedge clk);
        push_en   = 1'b1;
        push_data = 16'h1111;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            push_data = 16'h2222 + 16'(k);
            #1;
            check("R4 refused push_ready", DW'(push_ready), DW'(1'b0));
            @(negedge clk);
        end
        idle_inputs();
        check("R4 word kept", head_data, 16'h1111);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule